// File: doc/BRIEF.md
# Vector Configuration Setting Unit

This unit executes the vector configuration instructions. Each request carries a candidate vector type word and a requested element count (the AVL, taken from the rs1 operand). The unit checks whether the candidate type is legal for this implementation, then updates the vector type and vector length state registers. It also returns the new length as the value written to the destination register.

The type word comes from one of two operand forms. The immediate form takes an 11-bit zero-extended field. The register form takes the full XLEN-bit value from rs2, so a saved type word can be written back exactly during a context restore. This includes restoring the illegal state, which reads back as only the top bit set. Two flags mark rs1 and rd as x0. They select the length policy: clamp the AVL, take the maximum, or keep the current length.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, vtype_o holds only bit XLEN-1 set (0x80000000 for XLEN=32), vl_o is zero and rd_valid_o is low.
- R2: A legal request, when form_i is 1 (register form), loads vtype_o one cycle later with bits [7:0] of the operand (vlmul [2:0], vsew [5:3], tail policy bit 6, mask policy bit 7) and zero above.
- R3: When rs1 is not x0, vl_o becomes min(AVL, VLMAX), where VLMAX = VLEN*LMUL/SEW. SEW is 8<<vsew. LMUL encodings: vlmul 000..011 give 1,2,4,8 and 101,110,111 give 1/8,1/4,1/2.
- R4: When rs1 is x0 and rd is not x0, vl_o becomes VLMAX.
- R5: In the register form, any set operand bit from 8 up to and including XLEN-1 makes the request illegal. An illegal request leaves vtype_o with only bit XLEN-1 set and vl_o zero.
- R6: In the immediate form (form_i = 0), only operand bits [10:0] are examined. A set bit among [10:8] makes the request illegal, and bits 11 and above are ignored.
- R7: The following encodings are illegal:
  - vlmul 100;
  - vsew of 100 or above;
  - SEW above ELEN;
  - a fractional LMUL with SEW above LMUL*ELEN.
- R8: When rs1 and rd are both x0, vl_o is kept if the current type is legal and the new VLMAX equals the current VLMAX; otherwise the result is the illegal state.
- R9: rd_valid_o pulses one cycle after a request whose rd is not x0, with rd_wdata_o equal to the new vl_o (zero for an illegal setting).
- R10: Without a request, vtype_o and vl_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Configuration request this cycle |
| form_i | input | 1 | 0 = immediate type field, 1 = register type operand |
| rs1_val_i | input | XLEN | Requested element count (AVL) |
| rs2_val_i | input | XLEN | Candidate type word (immediate zero-extended, or register value) |
| rs1_is_x0_i | input | 1 | rs1 specifier is x0 |
| rd_is_x0_i | input | 1 | rd specifier is x0 |
| vtype_o | output | XLEN | Vector type state |
| vl_o | output | XLEN | Vector length state |
| rd_valid_o | output | 1 | Destination writeback strobe |
| rd_wdata_o | output | XLEN | Destination writeback value |

## Verification
The bench builds the unit with XLEN=32, VLEN=128 and ELEN=64. With these values VLMAX spans 2 to 128, so both the AVL clamp and the largest grouping are visible. Since ELEN is below 128, the e128 encoding is illegal, and the fractional limit splits cases such as e32,mf2 (legal) from e64,mf2 (illegal). The 32-bit width makes the illegal read-back value 0x80000000 and lets the bench set bit 31 in the immediate form to show it is ignored there.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int unsigned VT_W  = 8;   // architected vtype field width
  localparam int unsigned IMM_W = 11;  // immediate type field width

  typedef enum logic {
    FORM_IMM = 1'b0,
    FORM_REG = 1'b1
  } vcfg_form_e;

  typedef struct packed {
    logic       vma;
    logic       vta;
    logic [2:0] vsew;
    logic [2:0] vlmul;
  } vtype_fields_t;
endpackage

// File: rtl/vcfg_type_check.sv
module vcfg_type_check
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  localparam int unsigned VLEN_LOG = $clog2(VLEN),
  localparam int unsigned LOGW = $clog2(VLEN_LOG + 1)
) (
  input  logic            form_i,
  input  logic [XLEN-1:0] raw_i,
  output logic            legal_o,
  output logic [LOGW-1:0] vlmax_log_o
);
  localparam int ELEN_LOG = $clog2(ELEN);
  localparam logic [XLEN-1:0] REG_HI = ~XLEN'((1 << VT_W) - 1);
  localparam logic [XLEN-1:0] IMM_HI = XLEN'(((1 << IMM_W) - 1) & ~((1 << VT_W) - 1));

  vtype_fields_t f;
  logic hi_ok, lmul_ok, sew_ok, frac_ok;
  int   lmul_sh, sew_log, vlog;

  assign f = vtype_fields_t'(raw_i[VT_W-1:0]);

  always_comb begin
    hi_ok   = ((raw_i & ((form_i == FORM_REG) ? REG_HI : IMM_HI)) == '0);
    lmul_ok = 1'b1;
    case (f.vlmul)
      3'b000:  lmul_sh = 0;
      3'b001:  lmul_sh = 1;
      3'b010:  lmul_sh = 2;
      3'b011:  lmul_sh = 3;
      3'b101:  lmul_sh = -3;
      3'b110:  lmul_sh = -2;
      3'b111:  lmul_sh = -1;
      default: begin lmul_sh = 0; lmul_ok = 1'b0; end
    endcase
    sew_log = 3 + int'(f.vsew);
    sew_ok  = (sew_log <= ELEN_LOG);
    // fractional grouping: SEW must fit in LMUL*ELEN
    frac_ok = (sew_log <= ELEN_LOG + lmul_sh);
    vlog    = int'(VLEN_LOG) + lmul_sh - sew_log;
    legal_o = hi_ok & lmul_ok & sew_ok & frac_ok;
    vlmax_log_o = legal_o ? LOGW'(vlog) : '0;
  end
endmodule

// File: rtl/vcfg_len_select.sv
module vcfg_len_select #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned LOGW = 3
) (
  input  logic            legal_i,
  input  logic            rs1_x0_i,
  input  logic            rd_x0_i,
  input  logic [XLEN-1:0] avl_i,
  input  logic [LOGW-1:0] vlmax_log_i,
  input  logic            cur_legal_i,
  input  logic [LOGW-1:0] cur_vlmax_log_i,
  input  logic [XLEN-1:0] cur_vl_i,
  output logic            ok_o,
  output logic [XLEN-1:0] vl_o
);
  logic            keep;
  logic [XLEN-1:0] vlmax;

  assign keep  = rs1_x0_i & rd_x0_i;
  assign vlmax = XLEN'(1) << vlmax_log_i;
  assign ok_o  = legal_i & (~keep | (cur_legal_i & (cur_vlmax_log_i == vlmax_log_i)));

  always_comb begin
    if (!ok_o)         vl_o = '0;
    else if (keep)     vl_o = cur_vl_i;
    else if (rs1_x0_i) vl_o = vlmax;
    else               vl_o = (avl_i < vlmax) ? avl_i : vlmax;
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            form_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic            rs1_is_x0_i,
  input  logic            rd_is_x0_i,
  output logic [XLEN-1:0] vtype_o,
  output logic [XLEN-1:0] vl_o,
  output logic            rd_valid_o,
  output logic [XLEN-1:0] rd_wdata_o
);
  localparam int unsigned VLEN_LOG = $clog2(VLEN);
  localparam int unsigned LOGW = $clog2(VLEN_LOG + 1);
  localparam logic [XLEN-1:0] VILL = XLEN'(1) << (XLEN - 1);

  logic [XLEN-1:0] vtype_q, vl_q, rd_wdata_q, vl_nxt;
  logic [LOGW-1:0] vlmax_log_q, vlmax_log;
  logic            rd_valid_q, type_legal, ok;

  vcfg_type_check #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_check (
    .form_i      (form_i),
    .raw_i       (rs2_val_i),
    .legal_o     (type_legal),
    .vlmax_log_o (vlmax_log)
  );

  vcfg_len_select #(.XLEN(XLEN), .LOGW(LOGW)) u_len (
    .legal_i         (type_legal),
    .rs1_x0_i        (rs1_is_x0_i),
    .rd_x0_i         (rd_is_x0_i),
    .avl_i           (rs1_val_i),
    .vlmax_log_i     (vlmax_log),
    .cur_legal_i     (~vtype_q[XLEN-1]),
    .cur_vlmax_log_i (vlmax_log_q),
    .cur_vl_i        (vl_q),
    .ok_o            (ok),
    .vl_o            (vl_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vtype_q     <= VILL;
      vl_q        <= '0;
      vlmax_log_q <= '0;
      rd_valid_q  <= 1'b0;
      rd_wdata_q  <= '0;
    end else begin
      rd_valid_q <= req_valid_i & ~rd_is_x0_i;
      if (req_valid_i) begin
        vtype_q     <= ok ? {{(XLEN-VT_W){1'b0}}, rs2_val_i[VT_W-1:0]} : VILL;
        vl_q        <= vl_nxt;
        vlmax_log_q <= ok ? vlmax_log : '0;
        rd_wdata_q  <= vl_nxt;
      end
    end
  end

  assign vtype_o    = vtype_q;
  assign vl_o       = vl_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_wdata_o = rd_wdata_q;

  // R5
  vill_clears_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtype_q[XLEN-1] |-> (vtype_q[XLEN-2:0] == '0 && vl_q == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(vtype_q) && $stable(vl_q)));
  // R9
  rd_matches_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_q |-> (rd_wdata_q == vl_q));
  // R8
  keep_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rs1_is_x0_i && rd_is_x0_i) |=> (vtype_q[XLEN-1] || $stable(vl_q)));
  // R3
  avl_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rs1_is_x0_i) |=> (vl_q <= $past(rs1_val_i)));
endmodule

// File: tb/vcfg_unit_tb_top.sv
module vcfg_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] ILL = 32'h8000_0000;

  typedef struct packed {
    logic        form;
    logic [31:0] avl;
    logic [31:0] op;
    logic        rs1x0;
    logic        rdx0;
    logic [31:0] exp_vtype;
    logic [31:0] exp_vl;
    logic        exp_rdv;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 32'd10,  32'h00,        1'b0, 1'b0, 32'h00, 32'd10,  1'b1}, // R3 below VLMAX
    '{1'b0, 32'd100, 32'h00,        1'b0, 1'b0, 32'h00, 32'd16,  1'b1}, // R3 clamp
    '{1'b1, 32'd5,   32'hD2,        1'b0, 1'b0, 32'hD2, 32'd5,   1'b1}, // R2 policy bits kept
    '{1'b0, 32'd0,   32'h03,        1'b1, 1'b0, 32'h03, 32'd128, 1'b1}, // R4 e8,m8
    '{1'b0, 32'd0,   32'h0B,        1'b1, 1'b1, ILL,    32'd0,   1'b0}, // R8 ratio change
    '{1'b0, 32'd7,   32'h05,        1'b0, 1'b0, 32'h05, 32'd2,   1'b1}, // R3 fractional
    '{1'b0, 32'd0,   32'hC5,        1'b1, 1'b1, 32'hC5, 32'd2,   1'b0}, // R8 same type
    '{1'b1, 32'd0,   32'h0E,        1'b1, 1'b1, 32'h0E, 32'd2,   1'b0}, // R8 same ratio
    '{1'b1, 32'd3,   32'h8000_0000, 1'b0, 1'b0, ILL,    32'd0,   1'b1}, // R5 top bit
    '{1'b1, 32'd3,   32'h100,       1'b0, 1'b0, ILL,    32'd0,   1'b1}, // R5 bit 8
    '{1'b0, 32'd3,   32'h8000_0010, 1'b0, 1'b0, 32'h10, 32'd3,   1'b1}, // R6 high ignored
    '{1'b0, 32'd3,   32'h400,       1'b0, 1'b0, ILL,    32'd0,   1'b1}, // R6 bit 10
    '{1'b1, 32'd9,   32'h04,        1'b0, 1'b0, ILL,    32'd0,   1'b1}, // R7 vlmul 100
    '{1'b1, 32'd9,   32'h20,        1'b0, 1'b0, ILL,    32'd0,   1'b1}, // R7 e128
    '{1'b1, 32'd9,   32'h1F,        1'b0, 1'b0, ILL,    32'd0,   1'b1}, // R7 e64,mf2
    '{1'b1, 32'd9,   32'h17,        1'b0, 1'b0, 32'h17, 32'd2,   1'b1}, // R7 e32,mf2 legal
    '{1'b1, 32'd1,   32'h0D,        1'b0, 1'b0, ILL,    32'd0,   1'b1}, // R7 e16,mf8
    '{1'b1, 32'd0,   32'h00,        1'b1, 1'b1, ILL,    32'd0,   1'b0}, // R8 from illegal
    '{1'b0, 32'd0,   32'h18,        1'b0, 1'b0, 32'h18, 32'd0,   1'b1}, // R3 zero AVL
    '{1'b0, 32'd200, 32'h18,        1'b0, 1'b1, 32'h18, 32'd2,   1'b0}  // R9 rd is x0
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic            form_i = 1'b0;
  logic [XLEN-1:0] rs1_val_i = '0;
  logic [XLEN-1:0] rs2_val_i = '0;
  logic            rs1_is_x0_i = 1'b0;
  logic            rd_is_x0_i = 1'b0;
  logic [XLEN-1:0] vtype_o, vl_o, rd_wdata_o;
  logic            rd_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vcfg_unit #(.XLEN(XLEN), .VLEN(128), .ELEN(64)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .form_i, .rs1_val_i, .rs2_val_i,
    .rs1_is_x0_i, .rd_is_x0_i, .vtype_o, .vl_o, .rd_valid_o, .rd_wdata_o
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic f, logic [31:0] avl, logic [31:0] op, logic r1, logic rd);
    @(negedge clk_i);
    form_i = f; rs1_val_i = avl; rs2_val_i = op;
    rs1_is_x0_i = r1; rd_is_x0_i = rd; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic check_reset();
    check("R1", "vtype", vtype_o, ILL);
    check("R1", "vl", vl_o, 32'd0);
    check("R1", "rd_valid", {31'd0, rd_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset();
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].form, TBL[i].avl, TBL[i].op, TBL[i].rs1x0, TBL[i].rdx0);
      check($sformatf("vec%0d", i), "vtype", vtype_o, TBL[i].exp_vtype);
      check($sformatf("vec%0d", i), "vl", vl_o, TBL[i].exp_vl);
      check($sformatf("vec%0d R9", i), "rd_valid", {31'd0, rd_valid_o}, {31'd0, TBL[i].exp_rdv});
      if (TBL[i].exp_rdv)
        check($sformatf("vec%0d R9", i), "rd_wdata", rd_wdata_o, TBL[i].exp_vl);
    end

    // R10: idle cycles with changing operands leave state alone
    @(negedge clk_i);
    rs2_val_i = 32'h8000_0000; rs1_val_i = 32'd77; form_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R10", "vtype", vtype_o, 32'h18);
    check("R10", "vl", vl_o, 32'd2);
    check("R9", "rd_valid idle", {31'd0, rd_valid_o}, 32'd0);

    // R2: register form restores a legal saved value exactly
    issue(1'b1, 32'd1000, 32'h43, 1'b0, 1'b0);
    check("R2", "vtype", vtype_o, 32'h43);
    check("R3", "vl e8,m8 clamp", vl_o, 32'd128);

    // R1 again, then keep-vl straight from reset state is illegal (R8)
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check_reset();
    rst_ni = 1'b1;
    issue(1'b0, 32'd0, 32'h00, 1'b1, 1'b1);
    check("R8", "vtype after reset keep", vtype_o, ILL);
    check("R8", "vl after reset keep", vl_o, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule